// File: doc/BRIEF.md
# ALU Status Flag Register

This block holds the arithmetic status of a small ALU. It has five flags: negative, overflow, zero, digit carry and carry. In each cycle the ALU presents its two operands, an operation class and the result it produced. When the update strobe is high, the block works out the flags that class touches and loads them on the next rising edge. Flags that the class does not touch keep their values.

The register also has a direct write port. An instruction uses this port when the status register is its destination. If the same instruction also produces flags, the flag logic owns the bits it affects and the direct write reaches only the other bits. As a result, only operations with no flag effect (bit set or clear, nibble swap, moves) can rewrite every flag. The three upper bits are not implemented.

Subtraction is done by adding the two's complement of the second operand. Carry and digit carry therefore read as inverted borrows after a subtraction. Rotate-through-carry operations load carry and digit carry from source bits.

Top module: `alu_flag_reg`

## Requirements
- R1: Bits 7:5 of `stat` always read 0, even when the direct write drives ones into them.
- R2: After reset, `stat` is 0x00.
- R3: Add (class 1) sets C to the carry out of bit 7 and DC to the carry from bit 3 into bit 4. OV is set when adding two operands of the same sign gives a result of the other sign.
- R4: Subtract (class 2) computes opa minus opb. C is 1 when opa >= opb unsigned, and DC is 1 when opa[3:0] >= opb[3:0]; both are 0 on a borrow. OV is set when the signed difference falls outside -128..127.
- R5: For classes 1 to 5, N (bit 4) equals result[7], and Z (bit 2) is 1 exactly when result is 0x00.
- R6: Rotate left (class 3) loads C (bit 0) with opa[7] and DC (bit 1) with opa[3]. Rotate right (class 4) loads C with opa[0] and DC with opa[4]. OV (bit 3) is kept.
- R7: Logic (class 5) updates only N and Z. OV, DC and C are kept.
- R8: Clear (class 6) sets Z to 1 and keeps N, OV, DC and C.
- R9: With the update strobe low, or with class 0 or class 7 (no flag effect), the flags change only through the direct write. With the write enable also low, `stat` holds.
- R10: A direct write loads bits 4:0 from wr_data[4:0], with the layout N=4, OV=3, Z=2, DC=1, C=0.
- R11: When a flag update and a direct write occur in the same cycle, the bits the class affects take their flag values and the other bits take wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Flag update strobe |
| op_class | input | 3 | 0 none, 1 add, 2 sub, 3 rotate left, 4 rotate right, 5 logic, 6 clear, 7 none |
| opa | input | 8 | First ALU operand, also the rotate source |
| opb | input | 8 | Second ALU operand |
| result | input | 8 | ALU result for this operation |
| wr_en | input | 1 | Direct write enable (status register is the destination) |
| wr_data | input | 8 | Direct write value |
| stat | output | 8 | Register readback |

## Verification
The bench builds the block with its default data width of 8. At that width, every operand pair can be swept for both add and subtract, which covers each carry, digit-carry, borrow and overflow boundary. The same width also allows all rotate sources in both directions. Finally, it allows every combination of class, update strobe, write enable and 8-bit write value, so the arbitration between the direct write and flag updates is covered in full.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  typedef enum logic [2:0] {
    OPC_NONE  = 3'd0,
    OPC_ADD   = 3'd1,
    OPC_SUB   = 3'd2,
    OPC_RLC   = 3'd3,
    OPC_RRC   = 3'd4,
    OPC_LOGIC = 3'd5,
    OPC_CLR   = 3'd6,
    OPC_RSVD  = 3'd7
  } opc_e;

  localparam int STAT_W = 8;
  localparam int NFLAG  = 5;
  localparam int FB_C   = 0;
  localparam int FB_DC  = 1;
  localparam int FB_Z   = 2;
  localparam int FB_OV  = 3;
  localparam int FB_N   = 4;

  localparam logic [STAT_W-1:0] IMPL_MASK = STAT_W'((1 << NFLAG) - 1);
endpackage

// File: rtl/alu_flag_addsub.sv
module alu_flag_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic         c,
  output logic         dc,
  output logic         ov
);
  localparam int H = W / 2;

  logic [W-1:0] b_eff;
  logic [H:0]   lo_sum;
  logic [W:0]   full_sum;

  always_comb begin
    b_eff    = sub ? ~b : b;
    lo_sum   = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, sub};
    full_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    c        = full_sum[W];
    dc       = lo_sum[H];
    ov       = (a[W-1] == b_eff[W-1]) && (full_sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_flag_calc.sv
module alu_flag_calc
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  opc_e             op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [W-1:0]     result,
  output logic [NFLAG-1:0] mask,
  output logic [NFLAG-1:0] val
);
  localparam int H = W / 2;

  logic as_c, as_dc, as_ov;

  alu_flag_addsub #(.W(W)) addsub_i (
    .a   (a),
    .b   (b),
    .sub (op == OPC_SUB),
    .c   (as_c),
    .dc  (as_dc),
    .ov  (as_ov)
  );

  always_comb begin
    mask         = '0;
    val          = '0;
    val[FB_N]    = result[W-1];
    val[FB_Z]    = ~|result;
    unique case (op)
      OPC_ADD, OPC_SUB: begin
        mask       = '1;
        val[FB_C]  = as_c;
        val[FB_DC] = as_dc;
        val[FB_OV] = as_ov;
      end
      OPC_RLC: begin
        mask[FB_N]  = 1'b1;
        mask[FB_Z]  = 1'b1;
        mask[FB_DC] = 1'b1;
        mask[FB_C]  = 1'b1;
        val[FB_C]   = a[W-1];
        val[FB_DC]  = a[H-1];
      end
      OPC_RRC: begin
        mask[FB_N]  = 1'b1;
        mask[FB_Z]  = 1'b1;
        mask[FB_DC] = 1'b1;
        mask[FB_C]  = 1'b1;
        val[FB_C]   = a[0];
        val[FB_DC]  = a[H];
      end
      OPC_LOGIC: begin
        mask[FB_N] = 1'b1;
        mask[FB_Z] = 1'b1;
      end
      OPC_CLR: begin
        mask[FB_Z] = 1'b1;
        val[FB_Z]  = 1'b1;
      end
      default: mask = '0;
    endcase
  end
endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
  import alu_flag_pkg::*;
(
  input  logic              upd_en,
  input  logic [NFLAG-1:0]  mask,
  input  logic [NFLAG-1:0]  val,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic [STAT_W-1:0] cur,
  output logic [STAT_W-1:0] nxt
);
  logic [STAT_W-1:0] base;
  logic [STAT_W-1:0] eff_mask;
  logic [STAT_W-1:0] eff_val;

  always_comb begin
    base     = wr_en ? wr_data : cur;
    eff_mask = upd_en ? {{(STAT_W-NFLAG){1'b0}}, mask} : '0;
    eff_val  = {{(STAT_W-NFLAG){1'b0}}, val};
    nxt      = ((base & ~eff_mask) | (eff_val & eff_mask)) & IMPL_MASK;
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [2:0]        op_class,
  input  logic [W-1:0]      opa,
  input  logic [W-1:0]      opb,
  input  logic [W-1:0]      result,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] stat
);
  logic [NFLAG-1:0]  f_mask;
  logic [NFLAG-1:0]  f_val;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] stat_d;

  alu_flag_calc #(.W(W)) calc_i (
    .op     (opc_e'(op_class)),
    .a      (opa),
    .b      (opb),
    .result (result),
    .mask   (f_mask),
    .val    (f_val)
  );

  alu_flag_merge merge_i (
    .upd_en  (upd_en),
    .mask    (f_mask),
    .val     (f_val),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cur     (stat_q),
    .nxt     (stat_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;
endmodule

// File: rtl/alu_flag_reg_chk.sv
module alu_flag_reg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         upd_en,
  input logic [2:0]   op_class,
  input logic [W-1:0] opa,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic [7:0]   wr_data,
  input logic [7:0]   stat
);
  localparam int H = W / 2;

  logic nz_class;
  assign nz_class = (op_class >= 3'd1) && (op_class <= 3'd5);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !wr_en) |=> $stable(stat)); // R9

  AST_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !upd_en) |=> stat[4:0] == $past(wr_data[4:0])); // R10

  AST_RESULT_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && nz_class) |=> (stat[4] == $past(result[W-1])) && (stat[2] == ($past(result) == '0))); // R5

  AST_CLEAR_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_class == 3'd6) |=> stat[2]); // R8

  AST_CLEAR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_class == 3'd6 && !wr_en) |=> (stat[4:3] == $past(stat[4:3])) && (stat[1:0] == $past(stat[1:0]))); // R8

  AST_ROTL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_class == 3'd3) |=> (stat[0] == $past(opa[W-1])) && (stat[1] == $past(opa[H-1]))); // R6

  AST_ROTR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_class == 3'd4) |=> (stat[0] == $past(opa[0])) && (stat[1] == $past(opa[H]))); // R6

  AST_LOGIC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_class == 3'd5 && !wr_en) |=> (stat[3] == $past(stat[3])) && (stat[1:0] == $past(stat[1:0]))); // R7
endmodule

bind alu_flag_reg alu_flag_reg_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .upd_en   (upd_en),
  .op_class (op_class),
  .opa      (opa),
  .result   (result),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .stat     (stat)
);

// File: tb/alu_flag_reg_tb.sv
`timescale 1ns/1ps
module alu_flag_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_en = 1'b0;
  logic [2:0] op_class = 3'd0;
  logic [7:0] opa = 8'd0;
  logic [7:0] opb = 8'd0;
  logic [7:0] result = 8'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] stat;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 1'b0;
  logic [7:0] model = 8'h00;

  always #2 clk = ~clk;

  alu_flag_reg #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
    .opa(opa), .opb(opb), .result(result), .wr_en(wr_en),
    .wr_data(wr_data), .stat(stat)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] predict(input logic [7:0] cur, input bit upd, input int op,
                                         input int a, input int b, input int res,
                                         input bit wr, input logic [7:0] wd);
    int sa, sb, t;
    logic [4:0] m, v;
    logic [7:0] nx;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    m = 5'b0;
    v = 5'b0;
    v[4] = (res >= 128);
    v[2] = (res == 0);
    case (op)
      1: begin m = 5'b11111; v[0] = (a + b > 255); v[1] = ((a % 16) + (b % 16) > 15);
               t = sa + sb; v[3] = (t > 127) || (t < -128); end
      2: begin m = 5'b11111; v[0] = (a >= b); v[1] = ((a % 16) >= (b % 16));
               t = sa - sb; v[3] = (t > 127) || (t < -128); end
      3: begin m = 5'b10111; v[0] = ((a / 128) % 2 == 1); v[1] = ((a / 8) % 2 == 1); end
      4: begin m = 5'b10111; v[0] = (a % 2 == 1); v[1] = ((a / 16) % 2 == 1); end
      5: m = 5'b10100;
      6: begin m = 5'b00100; v[2] = 1'b1; end
      default: m = 5'b0;
    endcase
    if (!upd) m = 5'b0;
    nx = 8'h00;
    for (int i = 0; i < 5; i++) begin
      if (m[i])   nx[i] = v[i];
      else if (wr) nx[i] = wd[i];
      else        nx[i] = cur[i];
    end
    return nx;
  endfunction

  function automatic string req_of(input bit upd, input int op, input bit wr);
    if (upd && wr && op >= 1 && op <= 6) return "R11";
    if (!upd || op == 0 || op == 7) return wr ? "R10" : "R9";
    case (op)
      1: return "R3";
      2: return "R4";
      3, 4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic step(input bit upd, input int op, input int a, input int b,
                      input int res, input bit wr, input logic [7:0] wd);
    logic [7:0] exp;
    @(negedge clk);
    upd_en = upd; op_class = op[2:0]; opa = a[7:0]; opb = b[7:0];
    result = res[7:0]; wr_en = wr; wr_data = wd;
    exp = predict(model, upd, op, a, b, res, wr, wd);
    @(posedge clk);
    #1;
    check(req_of(upd, op, wr), stat, exp);
    if (upd && op >= 1 && op <= 5)  // R5 N and Z follow the result
      check("R5", {3'b0, stat[4], 1'b0, stat[2], 2'b0},
            {3'b0, res[7], 1'b0, (res[7:0] == 8'h00), 2'b0});
    if (wr && wd[7:5] != 3'b000) check("R1", {5'b0, stat[7:5]}, 8'h00);
    model = exp;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R2", stat, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 0, 0, 0, 0, 1'b1, 8'hFF);            // R1, R10
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        step(1'b1, 1, a, b, (a + b) % 256, 1'b0, 8'h00);   // R3
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        step(1'b1, 2, a, b, (a - b + 256) % 256, 1'b0, 8'h00); // R4
    for (int a = 0; a < 256; a++)
      for (int d = 0; d < 4; d++) begin           // R6 both directions, with and without write
        int rr;
        if (d % 2 == 0) rr = ((a * 2) % 256) + (model[0] ? 1 : 0);
        else            rr = (a / 2) + (model[0] ? 128 : 0);
        step(1'b1, 3 + (d % 2), a, 0, rr, d >= 2, 8'(a ^ 8'h5A));
      end
    for (int r = 0; r < 256; r++) begin           // R7
      step(1'b0, 0, 0, 0, 0, 1'b1, 8'(r));
      step(1'b1, 5, r, 0, r, 1'b0, 8'h00);
    end
    for (int w = 0; w < 256; w++) begin           // R8
      step(1'b0, 0, 0, 0, 0, 1'b1, 8'(w));
      step(1'b1, 6, w, 0, 0, 1'b0, 8'h00);
    end
    for (int u = 0; u < 2; u++)                   // R9, R10, R11, R1
      for (int op = 0; op < 8; op++)
        for (int wv = 0; wv < 2; wv++)
          for (int wd = 0; wd < 256; wd++)
            step(u == 1, op, (wd * 37) % 256, (wd * 91 + 13) % 256,
                 (wd * 53 + op) % 256, wv == 1, 8'(wd));
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule